// File: doc/BRIEF.md
# Flash Encryption Key and Policy Selector

This block sits between a bank of fused key slots and an XTS-mode AES engine. When asked, it scans six key slots for the one whose purpose code marks it as the XTS key. It undoes the byte order in which that key is stored and hands the engine two 128-bit AES keys: one for the data cipher and one for the tweak cipher. In the same scan it also works out two policy flags from fuse and control inputs. One flag says whether flash encryption is on. The other says whether software may trigger manual encryption.

A scan starts when `scan_req` is high at a rising clock edge. All outputs are registered, so they show the result of that scan from the next cycle onward. They keep that value until the next request, even if the inputs change in between. After reset, every output is zero until the first scan has completed.

Top module: `xts_key_policy_sel`

## Requirements
- R1: Slot s occupies purpose bits [4s+3:4s] and key bits [256s+255:256s]. Slots are scanned from 0 upward, and the first slot whose purpose code equals 4 is selected.
- R2: Let byte b of a key vector be bits [8b+7:8b]. Byte j of the corrected key equals byte 31-j of the selected slot's stored key.
- R3: When no slot carries purpose code 4, `key_found` is 0 and both key halves are all zeros. Codes other than 4 never match.
- R4: `data_key` holds corrected bytes 0 to 15, and `tweak_key` holds corrected bytes 16 to 31.
- R5: `flash_enc_en` is 1 exactly when the 3-bit boot crypt counter has an odd number of set bits.
- R6: `manual_enc_en` is 1 when control bit 0 is set, or when control bit 3 is set and `dl_manual_dis` is 0. No other control bit has any effect.
- R7: Outputs take the result of a scan one cycle after `scan_req` is sampled high. `key_valid` is 1 from then on.
- R8: During reset, and after reset until the first scan completes, `key_valid`, `key_found`, both key halves and both flags are 0.
- R9: While `scan_req` is low, changes on any input leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_req | input | 1 | Starts a scan and policy evaluation |
| slot_purpose | input | 24 | Six 4-bit purpose codes, slot 0 in the low bits |
| slot_key | input | 1536 | Six 256-bit stored keys, slot 0 in the low bits |
| boot_crypt_cnt | input | 3 | Boot crypt counter fuse field |
| ext_crypt_ctrl | input | 32 | External-device encrypt/decrypt control word |
| dl_manual_dis | input | 1 | Fuse that disables manual encryption in download mode |
| key_valid | output | 1 | At least one scan has completed |
| key_found | output | 1 | The last scan found an XTS key slot |
| data_key | output | 128 | Data-cipher AES-128 key |
| tweak_key | output | 128 | Tweak-cipher AES-128 key |
| flash_enc_en | output | 1 | Flash encryption enabled |
| manual_enc_en | output | 1 | Manual encryption enabled |

## Verification
The slot scan is exercised with several purpose patterns, each of which tells apart a different kind of fault:
- No match at all, including near-miss codes 3, 5 and 12. This separates an exact compare from a partial or ranged one.
- A single match in slot 0 and a single match in slot 5. These expose stuck or misindexed slot selection.
- Two matches, and all six slots matching. These show whether the lowest slot really has priority.

Every slot key has distinct byte values, so a missing reversal, an off-by-one reversal or swapped halves each give a different mismatch.

All eight counter values are tried, and the control word is tried with bit 0 alone, bit 3 with the fuse clear and set, both bits together, and only unrelated bits. Hold probes change every input while `scan_req` is low and confirm that the outputs do not move.

// File: rtl/xts_sel_pkg.sv
package xts_sel_pkg;
    localparam int KEY_BYTES  = 32;
    localparam int KEY_W      = KEY_BYTES * 8;
    localparam int HALF_W     = KEY_W / 2;

    typedef struct packed {
        logic              valid;
        logic              found;
        logic              flash_en;
        logic              manual_en;
        logic [KEY_W-1:0]  key;
    } sel_state_t;
endpackage

// File: rtl/slot_scan.sv
module slot_scan #(
    parameter int NUM_SLOTS  = 6,
    parameter int PURPOSE_W  = 4,
    parameter int KEY_W      = 256,
    parameter int MATCH_CODE = 4
) (
    input  logic [NUM_SLOTS*PURPOSE_W-1:0] purpose_flat,
    input  logic [NUM_SLOTS*KEY_W-1:0]     key_flat,
    output logic [NUM_SLOTS-1:0]           hit_oh,
    output logic                           any_hit,
    output logic [KEY_W-1:0]               key_pick
);
    logic [NUM_SLOTS-1:0] hit;
    logic [NUM_SLOTS-1:0] lower_hit;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cmp
        assign hit[i] = (purpose_flat[i*PURPOSE_W +: PURPOSE_W] == PURPOSE_W'(MATCH_CODE));
        if (i == 0) begin : g_first
            assign lower_hit[i] = 1'b0;
        end else begin : g_rest
            assign lower_hit[i] = lower_hit[i-1] | hit[i-1];
        end
    end

    assign hit_oh  = hit & ~lower_hit;
    assign any_hit = |hit;

    always_comb begin
        key_pick = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (hit_oh[i]) key_pick = key_pick | key_flat[i*KEY_W +: KEY_W];
        end
    end
endmodule

// File: rtl/byte_reverse.sv
module byte_reverse #(
    parameter int NBYTES = 32
) (
    input  logic [NBYTES*8-1:0] din,
    output logic [NBYTES*8-1:0] dout
);
    for (genvar j = 0; j < NBYTES; j++) begin : g_byte
        assign dout[j*8 +: 8] = din[(NBYTES-1-j)*8 +: 8];
    end
endmodule

// File: rtl/crypt_policy.sv
module crypt_policy #(
    parameter int CNT_W     = 3,
    parameter int CTRL_W    = 32,
    parameter int FORCE_BIT = 0,
    parameter int DL_BIT    = 3
) (
    input  logic [CNT_W-1:0]  boot_cnt,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              dl_dis,
    output logic              flash_now,
    output logic              manual_now
);
    logic unused_ctrl_bits;

    assign flash_now        = ^boot_cnt;
    assign manual_now       = ctrl[FORCE_BIT] | (ctrl[DL_BIT] & ~dl_dis);
    assign unused_ctrl_bits = ^ctrl;
endmodule

// File: rtl/xts_key_policy_sel.sv
module xts_key_policy_sel
    import xts_sel_pkg::*;
#(
    parameter int NUM_SLOTS  = 6,
    parameter int PURPOSE_W  = 4,
    parameter int MATCH_CODE = 4,
    parameter int CNT_W      = 3,
    parameter int CTRL_W     = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           scan_req,
    input  logic [NUM_SLOTS*PURPOSE_W-1:0] slot_purpose,
    input  logic [NUM_SLOTS*KEY_W-1:0]     slot_key,
    input  logic [CNT_W-1:0]               boot_crypt_cnt,
    input  logic [CTRL_W-1:0]              ext_crypt_ctrl,
    input  logic                           dl_manual_dis,
    output logic                           key_valid,
    output logic                           key_found,
    output logic [HALF_W-1:0]              data_key,
    output logic [HALF_W-1:0]              tweak_key,
    output logic                           flash_enc_en,
    output logic                           manual_enc_en
);
    logic [NUM_SLOTS-1:0] hit_oh;
    logic                 any_hit;
    logic [KEY_W-1:0]     key_raw;
    logic [KEY_W-1:0]     key_fixed;
    logic                 flash_now;
    logic                 manual_now;
    sel_state_t           st_d, st_q;

    slot_scan #(
        .NUM_SLOTS (NUM_SLOTS),
        .PURPOSE_W (PURPOSE_W),
        .KEY_W     (KEY_W),
        .MATCH_CODE(MATCH_CODE)
    ) u_scan (
        .purpose_flat(slot_purpose),
        .key_flat    (slot_key),
        .hit_oh      (hit_oh),
        .any_hit     (any_hit),
        .key_pick    (key_raw)
    );

    byte_reverse #(.NBYTES(KEY_BYTES)) u_rev (
        .din (key_raw),
        .dout(key_fixed)
    );

    crypt_policy #(
        .CNT_W    (CNT_W),
        .CTRL_W   (CTRL_W),
        .FORCE_BIT(0),
        .DL_BIT   (3)
    ) u_pol (
        .boot_cnt  (boot_crypt_cnt),
        .ctrl      (ext_crypt_ctrl),
        .dl_dis    (dl_manual_dis),
        .flash_now (flash_now),
        .manual_now(manual_now)
    );

    always_comb begin
        st_d = st_q;
        if (scan_req) begin
            st_d.valid     = 1'b1;
            st_d.found     = any_hit;
            st_d.key       = any_hit ? key_fixed : '0;
            st_d.flash_en  = flash_now;
            st_d.manual_en = manual_now;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign key_valid     = st_q.valid;
    assign key_found     = st_q.found;
    assign data_key      = st_q.key[HALF_W-1:0];
    assign tweak_key     = st_q.key[KEY_W-1:HALF_W];
    assign flash_enc_en  = st_q.flash_en;
    assign manual_enc_en = st_q.manual_en;

    a_r1_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_oh));
    a_r1_found_tracks_scan: assert property (@(posedge clk) disable iff (!rst_n)
        scan_req |=> key_found == $past(any_hit));
    a_r3_zero_without_match: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && !key_found) |-> (data_key == '0 && tweak_key == '0));
    a_r5_parity_flag: assert property (@(posedge clk) disable iff (!rst_n)
        scan_req |=> flash_enc_en == ^$past(boot_crypt_cnt));
    a_r6_manual_gate: assert property (@(posedge clk) disable iff (!rst_n)
        scan_req |=> manual_enc_en == ($past(ext_crypt_ctrl[0]) |
                                       ($past(ext_crypt_ctrl[3]) & !$past(dl_manual_dis))));
    a_r7_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        scan_req |=> key_valid);
    a_r8_stay_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_valid && !scan_req) |=> !key_valid);
    a_r9_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_req |=> ($stable(data_key) && $stable(tweak_key) && $stable(key_found)
                       && $stable(flash_enc_en) && $stable(manual_enc_en)));
endmodule

// File: tb/tb_xts_key_policy_sel.sv
`timescale 1ns/1ps
module tb_xts_key_policy_sel;
    typedef struct {
        logic         found;
        logic [127:0] dk;
        logic [127:0] tk;
        logic         fe;
        logic         me;
        string        tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scan_req = 1'b0;
    logic          probe = 1'b0;
    logic [23:0]   slot_purpose = '0;
    logic [1535:0] slot_key = '0;
    logic [2:0]    boot_crypt_cnt = '0;
    logic [31:0]   ext_crypt_ctrl = '0;
    logic          dl_manual_dis = 1'b0;
    logic          key_valid, key_found, flash_enc_en, manual_enc_en;
    logic [127:0]  data_key, tweak_key;

    exp_t exp_q[$];
    exp_t last_exp;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 0;

    always #4 clk = ~clk;

    xts_key_policy_sel dut (
        .clk(clk), .rst_n(rst_n), .scan_req(scan_req),
        .slot_purpose(slot_purpose), .slot_key(slot_key),
        .boot_crypt_cnt(boot_crypt_cnt), .ext_crypt_ctrl(ext_crypt_ctrl),
        .dl_manual_dis(dl_manual_dis),
        .key_valid(key_valid), .key_found(key_found),
        .data_key(data_key), .tweak_key(tweak_key),
        .flash_enc_en(flash_enc_en), .manual_enc_en(manual_enc_en)
    );

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1535:0] make_keys();
        logic [1535:0] k;
        for (int s = 0; s < 6; s++)
            for (int b = 0; b < 32; b++)
                k[s*256 + b*8 +: 8] = 8'(s*37 + b*11 + 5);
        return k;
    endfunction

    function automatic exp_t model(input logic [23:0] purp, input logic [1535:0] keys,
                                   input logic [2:0] cnt, input logic [31:0] ctrl,
                                   input logic dis, input string tag);
        exp_t e;
        logic [255:0] stored = '0;
        logic [255:0] fixed;
        e.found = 1'b0;
        for (int s = 0; s < 6; s++) begin
            if (!e.found && purp[s*4 +: 4] == 4'd4) begin
                e.found = 1'b1;
                stored  = keys[s*256 +: 256];
            end
        end
        for (int j = 0; j < 32; j++) fixed[j*8 +: 8] = stored[(31-j)*8 +: 8];
        e.dk  = fixed[127:0];
        e.tk  = fixed[255:128];
        e.fe  = (cnt[0] + cnt[1] + cnt[2]) % 2 == 1;
        e.me  = ctrl[0] || (ctrl[3] && !dis);
        e.tag = tag;
        return e;
    endfunction

    task automatic scan(input logic [23:0] purp, input logic [2:0] cnt,
                        input logic [31:0] ctrl, input logic dis, input string tag);
        @(negedge clk); #1;
        slot_purpose = purp; boot_crypt_cnt = cnt; ext_crypt_ctrl = ctrl;
        dl_manual_dis = dis; scan_req = 1'b1;
        last_exp = model(purp, slot_key, cnt, ctrl, dis, tag);
        exp_q.push_back(last_exp);
        @(negedge clk); #1;
        scan_req = 1'b0;
    endtask

    task automatic hold_probe(input string tag);
        exp_t e;
        @(negedge clk); #1;
        slot_purpose = ~slot_purpose; boot_crypt_cnt = ~boot_crypt_cnt;
        ext_crypt_ctrl = ~ext_crypt_ctrl; dl_manual_dis = ~dl_manual_dis;
        slot_key = {slot_key[1534:0], ~slot_key[1535]};
        probe = 1'b1;
        e = last_exp; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk); #1;
        probe = 1'b0;
    endtask

    // monitor: compares one queued item per strobe seen at the previous edge
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (scan_req || probe) begin
                if (exp_q.size() == 0) begin
                    check(0, "R7 unexpected result", 0, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(key_valid === 1'b1, {"R7 valid ", e.tag}, key_valid, 1);
                    check(key_found === e.found, {"R1 found ", e.tag}, key_found, e.found);
                    check(data_key === e.dk, {"R2 R4 data half ", e.tag}, data_key, e.dk);
                    check(tweak_key === e.tk, {"R2 R4 tweak half ", e.tag}, tweak_key, e.tk);
                    check(flash_enc_en === e.fe, {"R5 flash ", e.tag}, flash_enc_en, e.fe);
                    check(manual_enc_en === e.me, {"R6 manual ", e.tag}, manual_enc_en, e.me);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        slot_key = make_keys();
        slot_purpose = {6{4'd4}};
        boot_crypt_cnt = 3'b001;
        ext_crypt_ctrl = 32'h9;
        repeat (3) @(negedge clk);
        // R8: reset state
        check({key_valid, key_found, flash_enc_en, manual_enc_en} === 4'b0, "R8 flags in reset",
              {key_valid, key_found, flash_enc_en, manual_enc_en}, 0);
        check(data_key === '0 && tweak_key === '0, "R8 key in reset", data_key, 0);
        #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({key_valid, key_found, flash_enc_en, manual_enc_en} === 4'b0, "R8 before first scan",
              {key_valid, key_found, flash_enc_en, manual_enc_en}, 0);
        check(data_key === '0 && tweak_key === '0, "R8 key before first scan", tweak_key, 0);

        // R3: no match, including near-miss codes
        scan({4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0}, 3'b000, 32'h0, 1'b0, "R3 empty");
        scan({4'd5, 4'd3, 4'd12, 4'd5, 4'd3, 4'd12}, 3'b111, 32'h1, 1'b1, "R3 near-miss");
        // R1/R2/R4: single match slot 0, slot 5
        scan({4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd4}, 3'b011, 32'h8, 1'b0, "R1 slot0 only");
        hold_probe("R9 hold after slot0");
        scan({4'd4, 4'd1, 4'd2, 4'd3, 4'd5, 4'd6}, 3'b100, 32'h8, 1'b1, "R1 slot5 only");
        // R1 priority
        scan({4'd0, 4'd4, 4'd0, 4'd4, 4'd0, 4'd0}, 3'b010, 32'h9, 1'b1, "R1 slots2and4");
        scan({6{4'd4}}, 3'b101, 32'hFFFF_FFF6, 1'b0, "R1 all slots R6 other bits");
        hold_probe("R9 hold after all");
        // R5 sweep and R6 combos
        for (int c = 0; c < 8; c++)
            scan({4'd0, 4'd0, 4'd4, 4'd0, 4'd0, 4'd0}, 3'(c), (c % 2) ? 32'h1 : 32'h8,
                 c[1], "R5 counter sweep");
        scan({4'd4, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0}, 3'b110, 32'h0, 1'b0, "R6 no bits");
        hold_probe("R9 hold final");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R7 all results seen", exp_q.size(), 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule